// File: doc/BRIEF.md
# Multiframe-Aligned Time-Slot Capture Buffer

This block sits on a byte stream carrying an E1 PCM30 signal that has already been framed. It is attached to one chosen time slot out of 32. Every transferred byte comes with sideband fields: its slot number, and a flag that marks the first byte of a CRC-4 multiframe. The block keeps a frame index that restarts at each multiframe. A 16-entry receive store can record the chosen slot's byte from each of the 16 frames. A 16-entry transmit store can replace the chosen slot's byte on the way out, at the same index.

The receive side runs in one of three modes. In plain mode it overwrites its contents every multiframe. In stop mode it records until a masked 8-bit compare fires, on a match or on a mismatch. It then freezes and raises a status bit. In start mode it records nothing until the masked pattern arrives. It then records from that byte on and raises a different status bit. A small register port handles configuration, status, interrupt enables and access to both stores.

The stream passes through with no storage. `in_ready` is `out_ready`, and `out_valid` is `in_valid`. A byte is transferred only in a cycle where both `in_valid` and `out_ready` are high. While an upstream byte waits for `out_ready`, the block changes no state.

Top module: `slot_mf_buffer`

## Requirements
- R1: `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. Only a cycle with `in_valid` and `out_ready` both high is a transfer, and a stalled byte changes nothing.
- R2: The frame index is 0 for a transfer with `in_mfs`=1. It advances by one, modulo 16, after each transfer on the chosen slot.
- R3: Register 0 bits [4:0] select the slot, and bit 8 connects receive. While receive is connected, it records nothing until a transfer with `in_mfs`=1. From then on, in plain mode (bits [11:10]=00, or 11), each chosen-slot byte is written to entry `index`. The next multiframe overwrites it. Entry i reads at address 0x10+i.
- R4: With bit 8 clear, the receive store is never written.
- R5: With bit 9 set, and after any `in_mfs` transfer, `out_data` on a chosen-slot transfer is transmit entry `index`. Otherwise `out_data` equals `in_data`. Transmit entry i is written and read at address 0x20+i.
- R6: Register 1 holds the pattern in [7:0] and the mask in [15:8]. Only bits whose mask bit is 1 take part in the compare.
- R7: Stop mode is bits [11:10]=01. Bit 12 selects the trigger: 0 fires on a match, 1 fires on a mismatch. The triggering byte is still written. Recording then halts and status bit 0 (register 2) sets.
- R8: Start mode is bits [11:10]=10. No byte is written before the first matching chosen-slot byte. That byte and all later ones are written as in plain mode, and status bit 1 sets.
- R9: Status bits stay set until a 1 is written to them at register 2. `irq` is the OR of status AND enable, with the enables in register 3 bits [1:0].
- R10: After reset, every register and both stores read 0 and `irq` is low. Any write to register 0 re-arms the stop and start modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream byte present |
| in_ready | output | 1 | Block can take the byte |
| in_data | input | 8 | Slot byte |
| in_slot | input | 5 | Slot number of the byte |
| in_mfs | input | 1 | Byte is the first of a multiframe |
| out_valid | output | 1 | Downstream byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Slot byte, possibly replaced |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data, combinational |
| irq | output | 1 | Enabled status pending |

## Verification
The hardest situation to reach is a compare that fires at one chosen frame in the middle of a multiframe, with no earlier byte firing by chance. This matters most for the mismatch trigger, where random bytes would fire at once.

The stimulus generator fills the chosen slot in one of two ways. It can force the unmasked bits of each filler byte to equal the pattern and leave the masked-out bits random. Or it can redraw filler bytes until they miss the pattern. It then places a designed trigger byte at a chosen frame.

Random stalls on `out_ready` are mixed in throughout, so held bytes are shown to leave the index and the stores untouched.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_STOP  = 2'b01,
    MODE_START = 2'b10,
    MODE_RSVD  = 2'b11
  } cap_mode_e;

  localparam logic [5:0] REG_CTRL = 6'h00;
  localparam logic [5:0] REG_PAT  = 6'h01;
  localparam logic [5:0] REG_STAT = 6'h02;
  localparam logic [5:0] REG_IEN  = 6'h03;
  localparam logic [1:0] WIN_RX   = 2'b01;
  localparam logic [1:0] WIN_TX   = 2'b10;
endpackage

// File: rtl/smb_frame_index.sv
module smb_frame_index #(
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          mfs,
  input  logic          hit,
  output logic [IW-1:0] idx_now,
  output logic          aligned_now
);
  logic [IW-1:0] ptr_q;
  logic          aligned_q;

  assign idx_now     = mfs ? '0 : ptr_q;
  assign aligned_now = aligned_q | mfs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      aligned_q <= 1'b0;
    end else if (beat) begin
      if (mfs) aligned_q <= 1'b1;
      if (hit) ptr_q <= (idx_now == IW'(DEPTH - 1)) ? '0 : idx_now + 1'b1;
      else if (mfs) ptr_q <= '0;
    end
  end

  // R2: a boundary on another slot restarts the index
  p_index_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat && mfs && !hit |=> ptr_q == '0);
  // R2: one step per chosen-slot byte inside the multiframe
  p_index_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat && hit && !mfs && (ptr_q != IW'(DEPTH - 1)) |=> ptr_q == IW'($past(ptr_q) + 1'b1));
endmodule

// File: rtl/smb_pattern_cmp.sv
module smb_pattern_cmp (
  input  logic [7:0] data,
  input  logic [7:0] word,
  input  logic [7:0] mask,
  output logic       match
);
  assign match = ((data ^ word) & mask) == 8'h00;
endmodule

// File: rtl/smb_rx_engine.sv
module smb_rx_engine
  import smb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          hit,
  input  logic          mfs,
  input  logic          rx_en,
  input  cap_mode_e     mode,
  input  logic          stop_on_miss,
  input  logic          match,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    data,
  input  logic          ctrl_wr,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          stop_evt,
  output logic          start_evt
);
  logic       sync_q, frozen_q, started_q;
  logic       take, wr_en;
  logic [7:0] cells [DEPTH];

  assign take      = beat & hit & rx_en & (sync_q | mfs);
  assign stop_evt  = take && (mode == MODE_STOP) && !frozen_q && (stop_on_miss ? !match : match);
  assign start_evt = take && (mode == MODE_START) && !started_q && match;

  always_comb begin
    unique case (mode)
      MODE_STOP:  wr_en = take & !frozen_q;
      MODE_START: wr_en = take & (started_q | match);
      default:    wr_en = take;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q    <= 1'b0;
      frozen_q  <= 1'b0;
      started_q <= 1'b0;
    end else begin
      if (!rx_en) sync_q <= 1'b0;
      else if (beat && mfs) sync_q <= 1'b1;
      if (ctrl_wr) frozen_q <= 1'b0;
      else if (stop_evt) frozen_q <= 1'b1;
      if (ctrl_wr) started_q <= 1'b0;
      else if (start_evt) started_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [7:0] cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n) cell_q <= '0;
      else if (wr_en && idx == IW'(i)) cell_q <= data;
    end
    assign cells[i] = cell_q;
  end

  assign rd_data = cells[rd_idx];

  // R7: a trigger freezes recording
  p_stop_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt && !ctrl_wr |=> frozen_q);
  // R7: the freeze lasts until control is rewritten
  p_freeze_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q && !ctrl_wr |=> frozen_q);
  // R4: nothing is taken while disconnected
  p_no_take_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !take);
endmodule

// File: rtl/slot_mf_buffer.sv
module slot_mf_buffer
  import smb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SLOTS = 32,
  parameter int SW    = $clog2(SLOTS),
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic [SW-1:0] in_slot,
  input  logic          in_mfs,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  input  logic          cfg_we,
  input  logic [5:0]    cfg_addr,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  output logic          irq
);
  logic [SW-1:0] slot_q;
  logic          rx_en_q, tx_en_q, miss_q;
  cap_mode_e     mode_q;
  logic [7:0]    pat_q, mask_q;
  logic [1:0]    stat_q, ien_q, clr;
  logic          beat, hit, match, aligned_now, stop_evt, start_evt, ctrl_wr;
  logic [IW-1:0] idx_now;
  logic [7:0]    rx_rd;
  logic [7:0]    tx_cells [DEPTH];

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign beat      = in_valid & out_ready;
  assign hit       = in_slot == slot_q;
  assign ctrl_wr   = cfg_we && cfg_addr == REG_CTRL;

  smb_frame_index #(.DEPTH(DEPTH), .IW(IW)) u_idx (
    .clk, .rst_n, .beat, .mfs(in_mfs), .hit, .idx_now, .aligned_now
  );

  smb_pattern_cmp u_cmp (.data(in_data), .word(pat_q), .mask(mask_q), .match);

  smb_rx_engine #(.DEPTH(DEPTH), .IW(IW)) u_rx (
    .clk, .rst_n, .beat, .hit, .mfs(in_mfs), .rx_en(rx_en_q), .mode(mode_q),
    .stop_on_miss(miss_q), .match, .idx(idx_now), .data(in_data), .ctrl_wr,
    .rd_idx(cfg_addr[IW-1:0]), .rd_data(rx_rd), .stop_evt, .start_evt
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_tx
    logic [7:0] cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n) cell_q <= '0;
      else if (cfg_we && cfg_addr[5:4] == WIN_TX && cfg_addr[IW-1:0] == IW'(i))
        cell_q <= cfg_wdata[7:0];
    end
    assign tx_cells[i] = cell_q;
  end

  assign out_data = (tx_en_q && hit && aligned_now) ? tx_cells[idx_now] : in_data;

  assign clr = (cfg_we && cfg_addr == REG_STAT) ? cfg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q  <= '0;
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      mode_q  <= MODE_PLAIN;
      miss_q  <= 1'b0;
      pat_q   <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
      ien_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        slot_q  <= cfg_wdata[SW-1:0];
        rx_en_q <= cfg_wdata[8];
        tx_en_q <= cfg_wdata[9];
        mode_q  <= cap_mode_e'(cfg_wdata[11:10]);
        miss_q  <= cfg_wdata[12];
      end
      if (cfg_we && cfg_addr == REG_PAT) begin
        pat_q  <= cfg_wdata[7:0];
        mask_q <= cfg_wdata[15:8];
      end
      if (cfg_we && cfg_addr == REG_IEN) ien_q <= cfg_wdata[1:0];
      stat_q <= (stat_q & ~clr) | {start_evt, stop_evt};
    end
  end

  assign irq = |(stat_q & ien_q);

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr[5:4] == WIN_RX) cfg_rdata = {8'h00, rx_rd};
    else if (cfg_addr[5:4] == WIN_TX) cfg_rdata = {8'h00, tx_cells[cfg_addr[IW-1:0]]};
    else begin
      case (cfg_addr)
        REG_CTRL: cfg_rdata = {3'b000, miss_q, mode_q, tx_en_q, rx_en_q, 8'(slot_q)};
        REG_PAT:  cfg_rdata = {mask_q, pat_q};
        REG_STAT: cfg_rdata = {14'h0, stat_q};
        REG_IEN:  cfg_rdata = {14'h0, ien_q};
        default:  cfg_rdata = '0;
      endcase
    end
  end

  // R9: stop status is sticky until a one is written to it
  p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[0] && !(cfg_we && cfg_addr == REG_STAT && cfg_wdata[0]) |=> stat_q[0]);
  // R9: start status is sticky as well
  p_start_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[1] && !(cfg_we && cfg_addr == REG_STAT && cfg_wdata[1]) |=> stat_q[1]);
  // R1: a held byte leaves the index untouched
  p_stall_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !out_ready |=> $stable(u_idx.ptr_q));
endmodule

// File: tb/slot_mf_buffer_bench.sv
module slot_mf_buffer_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 0, in_ready, in_mfs = 0, out_valid, out_ready = 0;
  logic [7:0]  in_data = 0, out_data;
  logic [4:0]  in_slot = 0;
  logic        cfg_we = 0, irq;
  logic [5:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;

  always #4 clk = ~clk;

  slot_mf_buffer u_slot_mf_buffer (.*);

  int nchk = 0, nerr = 0;
  // reference model state, derived from the requirements
  logic [4:0] m_slot = 0;
  bit   m_rx = 0, m_tx = 0, m_miss = 0, m_aligned = 0, m_sync = 0, m_frozen = 0, m_started = 0;
  logic [1:0] m_mode = 0, m_stat = 0, m_ien = 0;
  logic [7:0] m_pat = 0, m_mask = 0;
  logic [3:0] m_idx = 0;
  logic [7:0] m_rxs [16];
  logic [7:0] m_txs [16];

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit masked_eq(logic [7:0] d);
    return ((d ^ m_pat) & m_mask) == 8'h00;
  endfunction

  function automatic logic [7:0] exp_out(logic [7:0] d, logic [4:0] s, bit mfs);
    logic [3:0] i = mfs ? 4'd0 : m_idx;
    if (m_tx && s == m_slot && (m_aligned || mfs)) return m_txs[i];
    return d;
  endfunction

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (a)
      6'h00: begin
        m_slot = d[4:0]; m_rx = d[8]; m_tx = d[9]; m_mode = d[11:10]; m_miss = d[12];
        m_frozen = 0; m_started = 0;
        if (!m_rx) m_sync = 0;
      end
      6'h01: begin m_pat = d[7:0]; m_mask = d[15:8]; end
      6'h02: m_stat = m_stat & ~d[1:0];
      6'h03: m_ien = d[1:0];
      default: if (a[5:4] == 2'b10) m_txs[a[3:0]] = d[7:0];
    endcase
  endtask

  task automatic rd_chk(logic [5:0] a, logic [15:0] e, string req);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(cfg_rdata == e, req, cfg_rdata, e);
  endtask

  task automatic beat(logic [7:0] d, logic [4:0] s, bit mfs);
    int stalls = $urandom_range(0, 2);
    logic [3:0] i;
    bit take, m;
    @(negedge clk);
    in_valid = 1; in_data = d; in_slot = s; in_mfs = mfs; out_ready = 0;
    for (int k = 0; k < stalls; k++) begin
      #1 chk(out_valid && !in_ready, "R1 stall", {out_valid, in_ready}, 2'b10);
      @(negedge clk);
    end
    out_ready = 1;
    #1 chk(out_data == exp_out(d, s, mfs), "R5 out_data", out_data, exp_out(d, s, mfs));
    @(posedge clk);
    i = mfs ? 4'd0 : m_idx;
    if (mfs) m_aligned = 1;
    take = (s == m_slot) && m_rx && (m_sync || mfs);
    if (mfs && m_rx) m_sync = 1;
    if (take) begin
      m = masked_eq(d);
      case (m_mode)
        2'b01: if (!m_frozen) begin
          m_rxs[i] = d;
          if (m_miss ? !m : m) begin m_frozen = 1; m_stat[0] = 1; end
        end
        2'b10: begin
          if (!m_started && m) begin m_started = 1; m_stat[1] = 1; end
          if (m_started) m_rxs[i] = d;
        end
        default: m_rxs[i] = d;
      endcase
    end
    if (s == m_slot) m_idx = i + 1;
    else if (mfs) m_idx = 0;
    #1 in_valid = 0; out_ready = $urandom_range(0, 1);
  endtask

  // one multiframe; the chosen slot carries trig_b at frame trig_f
  task automatic mframe(int trig_f, logic [7:0] trig_b, bit fill_eq);
    for (int f = 0; f < 16; f++)
      for (int s = 0; s < 32; s++) begin
        logic [7:0] d = 8'($urandom);
        if (5'(s) == m_slot) begin
          if (f == trig_f) d = trig_b;
          else if (fill_eq) d = (m_pat & m_mask) | (d & ~m_mask);
          else while (masked_eq(d) && m_mask != 0) d = 8'($urandom);
        end
        beat(d, 5'(s), f == 0 && s == 0);
      end
  endtask

  task automatic partial(int nf);
    for (int f = 0; f < nf; f++)
      for (int s = 0; s < 32; s++) beat(8'($urandom), 5'(s), 1'b0);
  endtask

  task automatic check_rx(string req);
    for (int i = 0; i < 16; i++) rd_chk(6'h10 + 6'(i), {8'h00, m_rxs[i]}, req);
  endtask

  task automatic check_irq(string req);
    rd_chk(6'h02, {14'h0, m_stat}, req);
    #1 chk(irq == |(m_stat & m_ien), req, irq, |(m_stat & m_ien));
  endtask

  bit done = 0;
  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin m_rxs[i] = 0; m_txs[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    rd_chk(6'h00, 16'h0, "R10 ctrl reset");
    rd_chk(6'h01, 16'h0, "R10 pattern reset");
    check_irq("R10 status reset");
    rd_chk(6'h13, 16'h0, "R10 rx reset");
    // R5: fill transmit store
    for (int i = 0; i < 16; i++) wr(6'h20 + 6'(i), 16'($urandom_range(0, 255)));
    rd_chk(6'h25, {8'h00, m_txs[5]}, "R5 tx readback");
    // R3: plain mode, no recording before a boundary, overwrite per multiframe
    wr(6'h00, 16'h0307);
    partial(3);
    check_rx("R3 waits for boundary");
    mframe(-1, 8'h00, 0);
    mframe(-1, 8'h00, 0);
    check_rx("R3 plain overwrite");
    // R2: chosen slot 0 coincides with the boundary
    wr(6'h00, 16'h0100);
    mframe(-1, 8'h00, 0);
    check_rx("R2 slot zero index");
    // R4: disconnected store stays unchanged, stream passes through
    wr(6'h00, 16'h0000);
    mframe(-1, 8'h00, 0);
    check_rx("R4 disconnected");
    // R7 + R6: stop on match, full mask
    wr(6'h01, 16'hFFA5);
    wr(6'h03, 16'h0003);
    wr(6'h00, 16'h050C);
    mframe(5, 8'hA5, 0);
    check_irq("R7 stop match status");
    mframe(-1, 8'h00, 0);
    check_rx("R7 frozen after match");
    check_irq("R9 sticky");
    wr(6'h02, 16'h0001);
    check_irq("R9 clear");
    // R7 + R6: stop on mismatch, upper nibble compared
    wr(6'h01, 16'hF030);
    wr(6'h00, 16'h1512);
    mframe(9, 8'h4C, 1);
    check_irq("R7 stop mismatch status");
    check_rx("R6 masked compare");
    // R8: start on pattern, lower nibble compared
    wr(6'h02, 16'h0003);
    wr(6'h03, 16'h0002);
    wr(6'h01, 16'h0F5A);
    wr(6'h00, 16'h091F);
    mframe(11, 8'h3A, 0);
    check_irq("R8 start status");
    check_rx("R8 start recording");
    mframe(-1, 8'h00, 0);
    check_rx("R8 continues");
    wr(6'h03, 16'h0000);
    check_irq("R9 masked irq");
    // random configurations
    for (int r = 0; r < 4; r++) begin
      wr(6'h02, 16'h0003);
      wr(6'h03, 16'($urandom_range(0, 3)));
      wr(6'h01, 16'($urandom));
      wr(6'h00, {3'b000, 1'($urandom), 2'($urandom), 1'($urandom), 1'b1, 3'b000, 5'($urandom)});
      mframe($urandom_range(0, 15), 8'($urandom), 1'($urandom));
      check_rx("R3 random");
      check_irq("R9 random");
    end
    done = 1;
    finish_run();
  end
endmodule